// File: doc/BRIEF.md
# Dual-Channel Interleaved ADC Capture Controller

This block sits on the logic side of a two-channel sampling converter that has a single 14-bit conversion core. Both channels share one parallel output bus. The controller owns the converter's digital control lines: the power-enable line, the sampling-mode line and the channel-select line. It toggles the channel-select line on every conversion clock. It records which channel was sampled on each clock, and it sorts the words coming back on the shared bus into a channel-1 stream and a channel-2 stream, each with its own valid strobe.

The converter has two sampling modes, and the return latency depends on the mode. In split mode the select line picks one channel per clock. In paired mode both channels are captured together on select-low clocks only, and the second channel's word comes back one clock after the first. The controller sequences power-up with a programmable settling count and discards the words from settling time. When the mode changes, it throws away every in-flight sample and holds off new samples for a fixed window. An output option turns offset-binary words into two's complement.

Top module: `ilv_adc_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output goes to zero after that edge: power line, mode line, select line, both valids and both data words.
- R2: After reset, `adc_chsel` inverts on every clock edge. It reads 1 after the first edge and 0 after the second.
- R3: `adc_pwr_n` follows `cfg_pwr_on` one clock later. No valid is raised after a clock at which power is low both before and after the edge.
- R4: Take `adc_pwr_n` as rising at edge p, with `cfg_startup_cycles` = N. The first edge whose sample may be reported is p+N+1. With default parameters, the first valid appears after edge p+N+11.
- R5: Split mode (`adc_simul` = 0). A sample is taken at edge k with the select line low before the edge (channel 1) or high (channel 2). Its bus word is reported on that channel's output after edge k+10, which is LAT+2.
- R6: Paired mode (`adc_simul` = 1). A select-low edge k reports channel 1 after edge k+10 and channel 2 after edge k+11. A select-high edge reports nothing.
- R7: `adc_simul` follows `cfg_simul` one clock later. The edge where they differ discards every sample not yet reported. No sample taken at that edge or at the following LAT+1 edges is reported. With default parameters, no valid appears after edges m+1 to m+19.
- R8: With `cfg_twos` = 1, the reported word is the bus word with bit 13 (the MSB) inverted. With `cfg_twos` = 0, it is the bus word unchanged.
- R9: `ch1_valid` and `ch2_valid` are never high in the same cycle.
- R10: An edge with `cfg_pwr_on` = 0 discards every sample not yet reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, shared with the converter |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pwr_on | input | 1 | Request normal operation (0 = power down) |
| cfg_simul | input | 1 | Requested sampling mode (1 = paired) |
| cfg_twos | input | 1 | Report two's complement instead of offset binary |
| cfg_startup_cycles | input | CNT_W | Settling clocks after power-up |
| adc_pwr_n | output | 1 | Converter power line, high = running |
| adc_simul | output | 1 | Converter sampling-mode line |
| adc_chsel | output | 1 | Converter channel-select line |
| adc_data | input | DW | Converter parallel output bus |
| ch1_data | output | DW | Channel-1 word |
| ch1_valid | output | 1 | Channel-1 word strobe |
| ch2_data | output | DW | Channel-2 word |
| ch2_valid | output | 1 | Channel-2 word strobe |

## Verification
The bench goes after the mode-dependent latency. If the tag tap were one stage off, the bench would see paired-mode channel-2 words carrying the next sample's data, or channel-1 and channel-2 words swapped in split mode. It switches mode and removes power while words are in flight. A design that failed to flush would then report stale words that the scoreboard no longer expects, with the wrong latency. It measures the first valid after power-up exactly, which catches an off-by-one in the settling count. It also changes the output format between runs, which would expose an inverted or missing MSB flip.

// File: rtl/ilv_adc_pkg.sv
// Shared types for the interleaved converter controller.
// Assumes a two-channel converter with one shared output bus.
package ilv_adc_pkg;
    localparam logic CH_ONE = 1'b0;
    localparam logic CH_TWO = 1'b1;

    // Record of what the converter was told to sample on one clock
    typedef struct packed {
        logic vld;
        logic ch;
    } slot_t;
endpackage

// File: rtl/ilv_adc_power.sv
// Power line driver and settling counter.
// Assumes the converter samples on every clock once its power line is high;
// ready rises once the power line has been high for limit further clocks.
module ilv_adc_power #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_req,
    input  logic [CNT_W-1:0] limit,
    output logic             pwr_q,
    output logic             ready
);
    logic [CNT_W-1:0] cnt_q;

    // Track the power request and count settling clocks while powered
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_req) begin
            pwr_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            pwr_q <= 1'b1;
            if (pwr_q && cnt_q != limit)
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Settling is over once the count has reached the limit
    always_comb ready = pwr_q && (cnt_q == limit);
endmodule

// File: rtl/ilv_adc_tagpipe.sv
// Channel-tag delay line. Each clock it records whether that clock's sample
// counts and which channel was selected. It then picks out the tags whose words
// are on the registered input bus now, using the latency of the current mode.
// Assumes the bus word is registered once before it is used here.
module ilv_adc_tagpipe
    import ilv_adc_pkg::*;
#(
    parameter int LAT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       push_vld,
    input  logic       push_ch,
    input  logic       simul,
    output logic [1:0] hit
);
    localparam int DEPTH = LAT + 3;
    localparam int TAP_A = LAT + 1;
    localparam int TAP_B = LAT + 2;

    slot_t sr [DEPTH];
    slot_t tap_a, tap_b;

    // Shift the tags along; a flush empties every stage
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
        end else begin
            sr[0] <= '{vld: push_vld, ch: push_ch};
            for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
        end
    end

    // Decode which channel the registered bus word belongs to
    always_comb begin
        tap_a = sr[TAP_A];
        tap_b = sr[TAP_B];
        if (simul) begin
            hit[0] = tap_a.vld && (tap_a.ch == CH_ONE);
            hit[1] = tap_b.vld && (tap_b.ch == CH_ONE);
        end else begin
            hit[0] = tap_a.vld && (tap_a.ch == CH_ONE);
            hit[1] = tap_a.vld && (tap_a.ch == CH_TWO);
        end
    end
endmodule

// File: rtl/ilv_adc_lane.sv
// One output channel: registers the bus word when tagged for this channel,
// optionally flipping the MSB for two's complement. Holds data otherwise.
module ilv_adc_lane #(
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic          twos,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          vout
);
    // Capture the tagged word and raise the strobe for one clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            vout <= 1'b0;
        end else begin
            vout <= hit;
            if (hit)
                dout <= twos ? {~din[DW-1], din[DW-2:0]} : din;
        end
    end
endmodule

// File: rtl/ilv_adc_ctrl.sv
// Controller for a two-channel converter with one shared output bus.
// Drives power, mode and channel-select lines, and splits returned words
// into two channel streams. Assumes a fixed converter latency of LAT clocks,
// plus one more clock for the second channel in paired mode.
module ilv_adc_ctrl
    import ilv_adc_pkg::*;
#(
    parameter int DW    = 14,
    parameter int LAT   = 8,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_pwr_on,
    input  logic             cfg_simul,
    input  logic             cfg_twos,
    input  logic [CNT_W-1:0] cfg_startup_cycles,
    output logic             adc_pwr_n,
    output logic             adc_simul,
    output logic             adc_chsel,
    input  logic [DW-1:0]    adc_data,
    output logic [DW-1:0]    ch1_data,
    output logic             ch1_valid,
    output logic [DW-1:0]    ch2_data,
    output logic             ch2_valid
);
    localparam int HOLD = LAT + 1;
    localparam int HW   = $clog2(HOLD + 1);

    logic          mode_chg, ready, push_vld, flush;
    logic [HW-1:0] hold_q;
    logic [DW-1:0] din_q;
    logic [1:0]    hit;
    logic [DW-1:0] ldata [2];
    logic          lvld  [2];

    // A mode request that differs from the line is a change at this edge
    always_comb mode_chg = (cfg_simul != adc_simul);
    always_comb push_vld = ready && !mode_chg && (hold_q == '0);
    always_comb flush    = mode_chg || !cfg_pwr_on;

    // Drive the sampling-mode line from the request
    always_ff @(posedge clk) begin
        if (!rst_n) adc_simul <= 1'b0;
        else        adc_simul <= cfg_simul;
    end

    // Hold off new samples for a fixed window after a mode change
    always_ff @(posedge clk) begin
        if (!rst_n)             hold_q <= '0;
        else if (mode_chg)      hold_q <= HW'(HOLD);
        else if (hold_q != '0)  hold_q <= hold_q - HW'(1);
    end

    // Alternate the channel-select line every clock
    always_ff @(posedge clk) begin
        if (!rst_n) adc_chsel <= 1'b0;
        else        adc_chsel <= ~adc_chsel;
    end

    // Register the converter bus before decoding
    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= '0;
        else        din_q <= adc_data;
    end

    ilv_adc_power #(.CNT_W(CNT_W)) u_pwr (
        .clk(clk), .rst_n(rst_n), .pwr_req(cfg_pwr_on),
        .limit(cfg_startup_cycles), .pwr_q(adc_pwr_n), .ready(ready)
    );

    ilv_adc_tagpipe #(.LAT(LAT)) u_tags (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push_vld(push_vld),
        .push_ch(adc_chsel), .simul(adc_simul), .hit(hit)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        ilv_adc_lane #(.DW(DW)) u_lane (
            .clk(clk), .rst_n(rst_n), .hit(hit[g]), .twos(cfg_twos),
            .din(din_q), .dout(ldata[g]), .vout(lvld[g])
        );
    end

    assign ch1_data  = ldata[0];
    assign ch1_valid = lvld[0];
    assign ch2_data  = ldata[1];
    assign ch2_valid = lvld[1];
endmodule

// File: rtl/ilv_adc_chk.sv
// Protocol checker for ilv_adc_ctrl, attached by bind.
module ilv_adc_chk #(
    parameter int LAT   = 8,
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adc_pwr_n,
    input logic             adc_simul,
    input logic             ch1_valid,
    input logic             ch2_valid,
    input logic [CNT_W-1:0] cfg_startup_cycles
);
    localparam int GW = $clog2(4 * LAT + 8) + 1;
    localparam int PW = CNT_W + 2;

    logic [GW-1:0] gap_q;
    logic          prev_simul;
    logic [PW-1:0] pw_q;

    // Clocks since the mode line last changed (saturating)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q      <= '1;
            prev_simul <= 1'b0;
        end else begin
            prev_simul <= adc_simul;
            if (adc_simul != prev_simul) gap_q <= '0;
            else if (gap_q != '1)        gap_q <= gap_q + GW'(1);
        end
    end

    // Clocks since the power line went high (saturating)
    always_ff @(posedge clk) begin
        if (!rst_n || !adc_pwr_n) pw_q <= '0;
        else if (pw_q != '1)      pw_q <= pw_q + PW'(1);
    end

    // R9
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ch1_valid && ch2_valid));

    // R3
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_pwr_n && $past(!adc_pwr_n)) |-> !(ch1_valid || ch2_valid));

    // R7
    mode_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_valid || ch2_valid) |-> (gap_q >= GW'(LAT + 1)));

    // R4
    settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_valid || ch2_valid) |-> (pw_q >= PW'(cfg_startup_cycles) + PW'(LAT + 2)));

    // R6
    pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch2_valid && $past(adc_simul)) |-> $past(ch1_valid));
endmodule

bind ilv_adc_ctrl ilv_adc_chk #(.LAT(LAT), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .adc_pwr_n(adc_pwr_n), .adc_simul(adc_simul),
    .ch1_valid(ch1_valid), .ch2_valid(ch2_valid),
    .cfg_startup_cycles(cfg_startup_cycles)
);

// File: tb/sim_ilv_adc_ctrl.sv
// Scoreboard bench: a converter model schedules bus words and pushes the
// expected reports; a monitor pops and compares as the design emits them.
module sim_ilv_adc_ctrl;
    localparam int DW = 14;
    localparam int LAT = 8;
    localparam int CNT_W = 20;

    typedef struct packed {
        logic [DW-1:0] v;
        logic [31:0]   due;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_pwr_on = 1'b0, cfg_simul = 1'b0, cfg_twos = 1'b0;
    logic [CNT_W-1:0] cfg_startup_cycles = '0;
    logic adc_pwr_n, adc_simul, adc_chsel;
    logic [DW-1:0] adc_data, bus_r, ch1_data, ch2_data;
    logic ch1_valid, ch2_valid;

    int n_chk = 0, n_bad = 0;
    int ecnt = 0, ucnt = 0, hold = 0;
    int pop1 = 0, pop2 = 0;
    logic [DW-1:0] sched [32];
    exp_t q1 [$];
    exp_t q2 [$];

    always #10 clk = ~clk;

    ilv_adc_ctrl #(.DW(DW), .LAT(LAT), .CNT_W(CNT_W)) u0 (.*);

    assign adc_data = adc_pwr_n ? bus_r : '0;

    function automatic logic [DW-1:0] sval(int k, logic ch);
        int t = k * 37 + (ch ? 6113 : 0) + 211;
        return t[DW-1:0];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Converter model and expectation driver
    always @(posedge clk) begin
        int k;
        bit chg, rep;
        k = ecnt;
        chg = (cfg_simul != adc_simul);
        rep = adc_pwr_n && cfg_pwr_on && !chg && hold == 0 && ucnt == int'(cfg_startup_cycles);
        if (chg || !cfg_pwr_on) begin
            while (q1.size() > 0 && q1[$].due > k) void'(q1.pop_back());
            while (q2.size() > 0 && q2[$].due > k) void'(q2.pop_back());
        end
        if (!adc_simul) begin
            sched[(k + 8) & 31] = sval(k, adc_chsel);
            if (rep) begin
                if (!adc_chsel) q1.push_back('{v: sval(k, 1'b0), due: k + 10});
                else            q2.push_back('{v: sval(k, 1'b1), due: k + 10});
            end
        end else if (!adc_chsel) begin
            sched[(k + 8) & 31] = sval(k, 1'b0);
            sched[(k + 9) & 31] = sval(k, 1'b1);
            if (rep) begin
                q1.push_back('{v: sval(k, 1'b0), due: k + 10});
                q2.push_back('{v: sval(k, 1'b1), due: k + 11});
            end
        end
        bus_r <= sched[k & 31];
        if (!adc_pwr_n) ucnt = 0;
        else if (ucnt != int'(cfg_startup_cycles)) ucnt = ucnt + 1;
        if (chg) hold = LAT + 1;
        else if (hold > 0) hold = hold - 1;
        ecnt <= ecnt + 1;
    end

    // Monitor: pop and compare every reported word
    always @(negedge clk) begin
        int e;
        string req;
        exp_t it;
        logic [DW-1:0] ev;
        e = ecnt - 1;
        req = cfg_twos ? "R8" : (adc_simul ? "R6" : "R5");
        if (rst_n) begin
            if (ch1_valid && ch2_valid) check(0, "R9 both strobes", 1, 0);
            if (ch1_valid) begin
                if (q1.size() == 0) check(0, {req, " unexpected ch1"}, int'(ch1_data), -1);
                else begin
                    it = q1.pop_front();
                    ev = cfg_twos ? (it.v ^ 14'h2000) : it.v;
                    check(ch1_data == ev, {req, " ch1 data"}, int'(ch1_data), int'(ev));
                    check(e == int'(it.due), {req, " ch1 timing"}, e, int'(it.due));
                    pop1++;
                end
            end
            if (ch2_valid) begin
                if (q2.size() == 0) check(0, {req, " unexpected ch2"}, int'(ch2_data), -1);
                else begin
                    it = q2.pop_front();
                    ev = cfg_twos ? (it.v ^ 14'h2000) : it.v;
                    check(ch2_data == ev, {req, " ch2 data"}, int'(ch2_data), int'(ev));
                    check(e == int'(it.due), {req, " ch2 timing"}, e, int'(it.due));
                    pop2++;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_quiet(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ch1_valid || ch2_valid) seen++;
        end
        check(seen == 0, tag, seen, 0);
    endtask

    initial begin
        int j, p1, p2;
        bit c0, c1;
        run(4);
        // R1 reset state
        check(!adc_pwr_n && !adc_simul && !adc_chsel, "R1 control lines", {adc_pwr_n, adc_simul, adc_chsel}, 0);
        check(!ch1_valid && !ch2_valid && ch1_data == 0 && ch2_data == 0, "R1 outputs", int'(ch1_data) + int'(ch2_data), 0);
        rst_n = 1'b1;
        @(negedge clk); c0 = adc_chsel;
        @(negedge clk); c1 = adc_chsel;
        check(c0 == 1'b1 && c1 == 1'b0, "R2 select toggles", {c0, c1}, 2);

        // Split mode power-up, settling 25
        cfg_startup_cycles = 25;
        cfg_pwr_on = 1'b1;
        check(adc_pwr_n == 1'b0, "R3 power before edge", adc_pwr_n, 0);
        j = 0;
        @(negedge clk);
        check(adc_pwr_n == 1'b1, "R3 power after edge", adc_pwr_n, 1);
        while (!(ch1_valid || ch2_valid) && j < 200) begin
            @(negedge clk);
            j++;
        end
        check(j == 25 + LAT + 3, "R4 first valid edge", j, 25 + LAT + 3);
        p1 = pop1; p2 = pop2;
        run(150);
        check(pop1 - p1 > 60 && pop2 - p2 > 60, "R5 both channels reported", pop2 - p2, 75);

        // Switch to paired mode
        cfg_simul = 1'b1;
        @(negedge clk);
        check(adc_simul == 1'b1, "R7 mode line", adc_simul, 1);
        count_quiet(18, "R7 holdoff after change");
        p1 = pop1; p2 = pop2;
        run(120);
        check(pop1 - p1 > 40 && pop1 - p1 - (pop2 - p2) <= 1 && pop1 - p1 - (pop2 - p2) >= 0,
              "R6 paired counts", pop2 - p2, pop1 - p1);

        // Power down in flight
        cfg_pwr_on = 1'b0;
        @(negedge clk);
        check(adc_pwr_n == 1'b0, "R3 power drops", adc_pwr_n, 0);
        count_quiet(15, "R10 no valid when off");
        check(q1.size() == 0 && q2.size() == 0, "R10 in-flight discarded", q1.size() + q2.size(), 0);

        // Two's complement, no settling, still paired
        cfg_twos = 1'b1;
        cfg_startup_cycles = 0;
        cfg_pwr_on = 1'b1;
        p1 = pop1;
        run(80);
        check(pop1 - p1 > 20, "R8 words reported", pop1 - p1, 30);

        // Back to split mode
        cfg_simul = 1'b0;
        @(negedge clk);
        check(adc_simul == 1'b0, "R7 mode line back", adc_simul, 0);
        count_quiet(18, "R7 holdoff back to split");
        p2 = pop2;
        run(80);
        check(pop2 - p2 > 20, "R5 split after paired", pop2 - p2, 30);

        cfg_pwr_on = 1'b0;
        run(20);
        check(q1.size() == 0 && q2.size() == 0, "R10 queues drained", q1.size() + q2.size(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule